// File: doc/BRIEF.md
# SDRAM Mode-Register Command Decoder

This block sits on the device side of a DDR SDRAM command bus. It watches the chip-select and the three command strobes, picks out the commands that load a mode register, and keeps the decoded fields in registers. The outputs are the DLL enable bit, the output-drive code, the CAS latency code and the burst length code. A bank-address bit chooses between the base register, which holds latency and burst length, and the extended register, which holds DLL enable and drive strength.

Every load is checked before it is stored. The clock enable must be high, every bank must be idle, no earlier update may still be in progress, and all reserved bits must be zero. A load that fails any check is dropped, the stored fields stay as they were, and a one-cycle error pulse is raised. Each accepted load opens an update window of two cycles. During that window `busy` is high, and any command that arrives is flagged as an error. The command pins are a plain sampled bus with no handshake. The block cannot push back, so a command that breaks a rule can only be reported through `err`.

Top module: `sdram_modereg_dec`

## Requirements
- R1: A load is decoded when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising edge. If the load is accepted, the selected fields show the new value in the cycle after that edge.
- R2: `ba[0]`=0 selects the base register and `ba[0]`=1 selects the extended register. A load changes only the fields of the register it selects.
- R3: In an extended load, `addr[0]`=0 gives `dll_en`=1 and `addr[0]`=1 gives `dll_en`=0.
- R4: `drv_code` is stored as {`addr[6]`,`addr[1]`}. Code 2'b01 is weak drive and code 2'b11 is matched impedance. An extended load with `addr[1]`=0 (code 00 or 10) is rejected.
- R5: Reserved bits must be zero. For an extended load these are `addr[11:7]`, `addr[5:2]` and `ba[1]`. For a base load these are `addr[11:7]`, `addr[3]` and `ba[1]`. A load with any of them set is rejected.
- R6: After an accepted load, `busy` is high for exactly 2 cycles. A command seen during that window raises `err`, and a load seen during that window is rejected. A command here means `cs_n` low with the three strobes not all high.
- R7: A load seen while `cke` is low, or while any bit of `bank_idle` is 0, is rejected.
- R8: `ext_valid` is 0 after reset. The first accepted extended load sets it, and after that it stays at 1 until the next reset.
- R9: A base load stores `cas_lat`=`addr[6:4]` and `burst_len`=`addr[2:0]`. Legal burst codes are 1, 2 and 3. Legal latency codes are 2, 3 and 6. While `ext_valid`=1 and `dll_en`=0, only latency codes 2 and 3 are legal.
- R10: While `cs_n` is high, all inputs are ignored. No field, `busy` or `err` changes.
- R11: `err` is high for the single cycle after each offending edge. A rejected load leaves every stored field unchanged.
- R12: Reset is synchronous and active-high. It sets `busy`=0, `err`=0, `ext_valid`=0, `cas_lat`=3, `burst_len`=1, `dll_en`=1 and `drv_code`=2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the command bus is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; must be high for a load to be accepted |
| cs_n | input | 1 | Chip-select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address; bit 0 selects the register, bit 1 is reserved |
| addr | input | 12 | Address bus that carries the register fields |
| bank_idle | input | 4 | One bit per bank, 1 when that bank is precharged |
| dll_en | output | 1 | Stored DLL enable |
| drv_code | output | 2 | Stored output-drive code |
| cas_lat | output | 3 | Stored CAS latency code |
| burst_len | output | 3 | Stored burst length code |
| ext_valid | output | 1 | Extended register has been loaded since reset |
| busy | output | 1 | Update window in progress |
| err | output | 1 | One-cycle pulse on an illegal command |

## Verification
Every result here is registered, so the stored fields, `err` and `busy` change in the cycle after the edge that sampled the command. `busy` then stays high for one more cycle and is low in the third. The bench drives the command half a cycle before the sampling edge. It returns the bus to NOP at the following falling edge and reads the outputs at that same falling edge. The `busy` window and the end of the `err` pulse are checked at the next two falling edges. Tests for the busy window send commands on consecutive edges, so they land in the first and in the second cycle of the window.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef struct packed {
    logic [2:0] cl;
    logic [2:0] bl;
  } base_fields_t;

  typedef struct packed {
    logic       dll_en;
    logic [1:0] drv;
  } ext_fields_t;

  localparam logic [1:0] DRV_WEAK    = 2'b01;
  localparam logic [1:0] DRV_MATCHED = 2'b11;

  localparam logic [2:0] CL_TWO      = 3'd2;
  localparam logic [2:0] CL_THREE    = 3'd3;
  localparam logic [2:0] CL_TWO_HALF = 3'd6;

  localparam base_fields_t BASE_RST = '{cl: 3'd3, bl: 3'd1};
  localparam ext_fields_t  EXT_RST  = '{dll_en: 1'b1, drv: DRV_WEAK};

  function automatic logic bl_legal(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic cl_legal(input logic [2:0] code, input logic dll_off);
    return (code == CL_TWO) || (code == CL_THREE) ||
           ((code == CL_TWO_HALF) && !dll_off);
  endfunction

endpackage

// File: rtl/mrd_cmd_decode.sv
module mrd_cmd_decode
  import mrd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 busy,
  input  logic                 dll_off,
  output logic                 cmd_seen,
  output logic                 accept_base,
  output logic                 accept_ext,
  output logic                 reject,
  output base_fields_t         base_new,
  output ext_fields_t          ext_new
);

  logic [ADDR_W-1:0] ext_keep;
  logic [ADDR_W-1:0] base_keep;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    localparam bit EXT_K  = (i == 0) || (i == 1) || (i == 6);
    localparam bit BASE_K = (i <= 2) || ((i >= 4) && (i <= 6));
    assign ext_keep[i]  = EXT_K;
    assign base_keep[i] = BASE_K;
  end

  logic load_seen, gate_ok;
  logic ext_rsv_ok, base_rsv_ok, ext_ok, base_ok;

  always_comb begin
    load_seen = !cs_n && !ras_n && !cas_n && !we_n;
    cmd_seen  = !cs_n && !(ras_n && cas_n && we_n);
    gate_ok   = cke && (&bank_idle) && !busy;

    ext_rsv_ok  = ((addr & ~ext_keep) == '0) && !ba[1];
    base_rsv_ok = ((addr & ~base_keep) == '0) && !ba[1];

    ext_new.dll_en = !addr[0];
    ext_new.drv    = {addr[6], addr[1]};
    base_new.cl    = addr[6:4];
    base_new.bl    = addr[2:0];

    ext_ok  = ext_rsv_ok && addr[1];
    base_ok = base_rsv_ok && bl_legal(base_new.bl) && cl_legal(base_new.cl, dll_off);

    accept_ext  = load_seen && gate_ok && ba[0] && ext_ok;
    accept_base = load_seen && gate_ok && !ba[0] && base_ok;
    reject      = (load_seen && !accept_ext && !accept_base) || (cmd_seen && busy);
  end

  // R7
  cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (load_seen && !cke) |-> reject);

  // R10
  cs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !(accept_base || accept_ext || reject));

endmodule

// File: rtl/mrd_upd_window.sv
module mrd_upd_window #(
  parameter int UPD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(UPD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UPD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R6
  window_open_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LOAD);

endmodule

// File: rtl/mrd_regs.sv
module mrd_regs
  import mrd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         accept_base,
  input  logic         accept_ext,
  input  logic         reject,
  input  base_fields_t base_new,
  input  ext_fields_t  ext_new,
  output base_fields_t base_q,
  output ext_fields_t  ext_q,
  output logic         ext_valid,
  output logic         err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= BASE_RST;
      ext_q     <= EXT_RST;
      ext_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= reject;
      if (accept_base) base_q <= base_new;
      if (accept_ext) begin
        ext_q     <= ext_new;
        ext_valid <= 1'b1;
      end
    end
  end

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ext_valid |=> ext_valid);

  // R11
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reject && !accept_base && !accept_ext) |=> ($stable(base_q) && $stable(ext_q)));

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> err);

endmodule

// File: rtl/sdram_modereg_dec.sv
module sdram_modereg_dec
  import mrd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter int UPD_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic                 dll_en,
  output logic [1:0]           drv_code,
  output logic [2:0]           cas_lat,
  output logic [2:0]           burst_len,
  output logic                 ext_valid,
  output logic                 busy,
  output logic                 err
);

  logic         cmd_seen, accept_base, accept_ext, reject, dll_off;
  base_fields_t base_new, base_q;
  ext_fields_t  ext_new, ext_q;

  assign dll_off = ext_valid && !ext_q.dll_en;

  mrd_cmd_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .clk, .rst, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr, .bank_idle,
    .busy, .dll_off, .cmd_seen, .accept_base, .accept_ext, .reject,
    .base_new, .ext_new
  );

  mrd_upd_window #(.UPD_CYC(UPD_CYC)) u_win (
    .clk, .rst, .start(accept_base || accept_ext), .busy
  );

  mrd_regs u_regs (
    .clk, .rst, .accept_base, .accept_ext, .reject, .base_new, .ext_new,
    .base_q, .ext_q, .ext_valid, .err
  );

  assign dll_en    = ext_q.dll_en;
  assign drv_code  = ext_q.drv;
  assign cas_lat   = base_q.cl;
  assign burst_len = base_q.bl;

  // R6
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_seen) |=> err);

  // R9
  slow_cl_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_base && dll_off) |=> (cas_lat == CL_TWO || cas_lat == CL_THREE));

  // R2
  one_reg_chk: assert property (@(posedge clk) disable iff (rst)
    accept_base |=> $stable(ext_q));

endmodule

// File: tb/sdram_modereg_dec_tb.sv
module sdram_modereg_dec_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bank_idle = 4'hF;
  logic        dll_en, ext_valid, busy, err;
  logic [1:0]  drv_code;
  logic [2:0]  cas_lat, burst_len;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic       e_dll, e_valid;
  logic [1:0] e_drv;
  logic [2:0] e_cl, e_bl;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_modereg_dec dut_i (
    .clk, .rst, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr, .bank_idle,
    .dll_en, .drv_code, .cas_lat, .burst_len, .ext_valid, .busy, .err
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check({req, " dll_en"},    dll_en,    e_dll);
    check({req, " drv_code"},  drv_code,  e_drv);
    check({req, " cas_lat"},   cas_lat,   e_cl);
    check({req, " burst_len"}, burst_len, e_bl);
    check({req, " ext_valid"}, ext_valid, e_valid);
  endtask

  // Called at a falling edge: drive, let the rising edge sample, restore NOP.
  task automatic send(input logic c, input logic r, input logic ca, input logic w,
                      input logic [1:0] b, input logic [11:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
  endtask

  task automatic load(input logic [1:0] b, input logic [11:0] a);
    send(1'b0, 1'b0, 1'b0, 1'b0, b, a);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 busy", busy, 0);
    check("R12 err", err, 0);
    check_regs("R12 R8");
  endtask

  task automatic t_ext_weak_on();
    load(2'b01, 12'h002);
    e_dll = 1; e_drv = 2'b01; e_valid = 1;
    check_regs("R1 R3 R8");
    check("R1 err", err, 0);
    check("R6 busy c1", busy, 1);
    @(negedge clk); check("R6 busy c2", busy, 1);
    @(negedge clk); check("R6 busy c3", busy, 0);
    settle();
  endtask

  task automatic t_ext_matched_off();
    load(2'b01, 12'h043);
    e_dll = 0; e_drv = 2'b11;
    check_regs("R3 R4 matched");
    settle();
  endtask

  task automatic t_base_load();
    load(2'b00, 12'h032);
    e_cl = 3; e_bl = 2;
    check_regs("R2 R9 base");
    check("R9 err", err, 0);
    settle();
  endtask

  task automatic t_slow_cl();
    load(2'b00, 12'h063);
    check("R9 cl6 dll off err", err, 1);
    check_regs("R9 cl6 dll off hold");
    settle();
    load(2'b00, 12'h023);
    e_cl = 2; e_bl = 3;
    check_regs("R9 cl2 dll off");
    settle();
    load(2'b00, 12'h034);
    check("R9 bl4 err", err, 1);
    check_regs("R9 bl4 hold");
    settle();
  endtask

  task automatic t_reserved();
    load(2'b01, 12'h006);
    check("R5 ext bit2 err", err, 1);
    check_regs("R5 ext hold");
    @(negedge clk); check("R11 err pulse ends", err, 0);
    settle();
    load(2'b10, 12'h032);
    check("R5 ba1 err", err, 1);
    check_regs("R5 ba1 hold");
    settle();
    load(2'b00, 12'h03A);
    check("R5 base bit3 err", err, 1);
    check("R5 no busy", busy, 0);
    check_regs("R5 base hold");
    settle();
  endtask

  task automatic t_drive_bad();
    load(2'b01, 12'h040);
    check("R4 code10 err", err, 1);
    check_regs("R4 code10 hold");
    settle();
    load(2'b01, 12'h000);
    check("R4 code00 err", err, 1);
    check_regs("R4 code00 hold");
    settle();
  endtask

  task automatic t_gate();
    bank_idle = 4'b1011;
    load(2'b01, 12'h002);
    bank_idle = 4'hF;
    check("R7 bank busy err", err, 1);
    check_regs("R7 bank hold");
    settle();
    cke = 1'b0;
    load(2'b00, 12'h032);
    cke = 1'b1;
    check("R7 cke low err", err, 1);
    check_regs("R7 cke hold");
    settle();
  endtask

  task automatic t_cs_high();
    send(1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 12'h002);
    check("R10 err", err, 0);
    check("R10 busy", busy, 0);
    check_regs("R10 hold");
    send(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 12'h000);
    check("R6 idle activate no err", err, 0);
    check("R6 idle activate no busy", busy, 0);
    settle();
  endtask

  task automatic t_busy_window();
    load(2'b01, 12'h002);
    e_dll = 1; e_drv = 2'b01;
    check_regs("R6 open");
    send(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 12'h000);
    check("R6 cmd in window err", err, 1);
    load(2'b00, 12'h031);
    check("R6 load in window err", err, 1);
    check("R6 window closed", busy, 0);
    check_regs("R6 load in window hold");
    settle();
    load(2'b00, 12'h063);
    e_cl = 6; e_bl = 3;
    check_regs("R9 cl6 dll on");
    settle();
  endtask

  initial begin
    e_dll = 1; e_drv = 2'b01; e_cl = 3; e_bl = 1; e_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ext_weak_on();
    t_ext_matched_off();
    t_base_load();
    t_slow_cl();
    t_reserved();
    t_drive_bad();
    t_gate();
    t_cs_high();
    t_busy_window();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule